// File: doc/BRIEF.md
# System Clock Source Switch with Oscillator Loss Guard

This block chooses which of three clock sources drives the system: an internal RC oscillator, an external crystal oscillator, or a PLL. Software writes a 2-bit select code. The block moves the system onto the named source only when that source reports ready. A 2-bit status field shows the source that is really in use. The analog glitch-free clock multiplexer and the oscillators themselves are outside the block. The block drives the multiplexer through a select output and drives each oscillator through an enable output. Each oscillator returns a ready input.

A loss guard watches the external oscillator through a failure-detect input. The guard arms only when it is enabled, the external oscillator is enabled, and that oscillator reports ready. When it sees a loss, it does four things in one step: it turns the external oscillator off, raises a sticky failure flag, holds a non-maskable interrupt request, and sends a one-cycle break pulse to the motor-control timer. If the system was running from the lost oscillator, or from a PLL fed by it, the system drops back to the internal RC and the PLL is turned off. Software clears the flag by writing a one to the clear command.

The reported external-ready flag does not fall as soon as the oscillator is disabled. It stays up for a set number of cycles, as the real oscillator does when it winds down.

Top module: `clksw_top`

## Requirements
- R1: The select code and the status field use the same encoding: 00 is the internal RC, 01 is the external oscillator and 10 is the PLL. The status field and `clkSel` never show 11.
- R2: After reset the status is 00, `intOn` and `intRdy` are 1, and `extOn`, `pllOn`, `failFlag`, `nmiReq` and `timBreak` are 0.
- R3: A pending select takes effect on the clock edge after the named source's ready output is 1. Until then the status field keeps the old source.
- R4: A select write of code 11 is ignored, and the pending request from earlier writes is kept.
- R5: A write to the PLL input select (1 = external oscillator, 0 = internal RC) takes effect only while `pllOn` is 0.
- R6: The guard reacts to `extLossIn` only while `monEn`, `extOn` and `extRdy` are all 1. At any other time `extLossIn` has no effect.
- R7: On a detected loss, `extOn` goes to 0 and `failFlag` goes to 1 on the next edge. `timBreak` is 1 for exactly one cycle. `nmiReq` stays 1 for as long as `failFlag` is 1.
- R8: A loss forces the status to 00, clears `pllOn` and sets `intOn` in two cases: when the status was 01, or when the status was 10 with `pllFromExt` at 1. In every other case the loss leaves the status and `pllOn` unchanged.
- R9: A clear write with data 1 clears `failFlag` and `nmiReq`. A clear write with data 0 has no effect.
- R10: After `extOn` is cleared, `extRdy` stays 1 for OFF_DELAY (default 6) cycles while the oscillator input stays ready, and then drops to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| selWr | input | 1 | Select write strobe |
| selData | input | 2 | Requested source code |
| intOnWr | input | 1 | Internal RC enable write strobe |
| intOnData | input | 1 | Internal RC enable value |
| extOnWr | input | 1 | External oscillator enable write strobe |
| extOnData | input | 1 | External oscillator enable value |
| pllOnWr | input | 1 | PLL enable write strobe |
| pllOnData | input | 1 | PLL enable value |
| pllSrcWr | input | 1 | PLL input select write strobe |
| pllSrcData | input | 1 | PLL input select value (1 = external) |
| monEnWr | input | 1 | Loss guard enable write strobe |
| monEnData | input | 1 | Loss guard enable value |
| failClrWr | input | 1 | Failure clear command strobe |
| failClrData | input | 1 | Clear command bit, only 1 acts |
| intRdyIn | input | 1 | Internal RC stable |
| extRdyIn | input | 1 | External oscillator stable |
| pllRdyIn | input | 1 | PLL locked |
| extLossIn | input | 1 | External oscillator loss detected |
| clkSel | output | 2 | Select to the glitch-free clock multiplexer |
| selStatus | output | 2 | Source in use |
| intOn | output | 1 | Internal RC enable |
| extOn | output | 1 | External oscillator enable |
| pllOn | output | 1 | PLL enable |
| pllFromExt | output | 1 | PLL fed by the external oscillator |
| monEn | output | 1 | Loss guard enabled |
| intRdy | output | 1 | Internal RC ready flag |
| extRdy | output | 1 | External oscillator ready flag |
| pllRdy | output | 1 | PLL ready flag |
| failFlag | output | 1 | Sticky loss flag |
| nmiReq | output | 1 | Non-maskable interrupt request |
| timBreak | output | 1 | One-cycle break pulse to the timer |

## Verification
The assertions assume the following about the inputs:
- Every write strobe lasts one cycle.
- A ready input stays high for the whole time its source is in use.
- `extLossIn` is raised only as a single-cycle pulse.

Under these assumptions, a second loss cannot arrive in the cycle after a break pulse, and the PLL input select can change only while the PLL is off. The stimulus drives each write for exactly one cycle and sets the ready inputs before the switches that depend on them. It pulses the loss input once in each scenario and clears the flag before the next one, so every assumed input pattern holds throughout the run.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SRC_RC   = 2'b00,
    SRC_XTAL = 2'b01,
    SRC_PLL  = 2'b10,
    SRC_NONE = 2'b11
  } srcSel_e;

  typedef struct packed {
    logic    loadReq;
    srcSel_e reqVal;
    logic    commit;
    logic    forceRc;
    logic    setIntOn;
    logic    clrIntOn;
    logic    setExtOn;
    logic    clrExtOn;
    logic    setPllOn;
    logic    clrPllOn;
    logic    loadPllSrc;
    logic    pllSrcVal;
    logic    setMon;
    logic    clrMon;
    logic    setFail;
    logic    clrFail;
    logic    fireBreak;
  } ctlStrobe_t;

endpackage

// File: rtl/clksw_ctrl.sv
module clksw_ctrl
  import clksw_pkg::*;
(
  input  logic       selWr,
  input  logic [1:0] selData,
  input  logic       intOnWr,
  input  logic       intOnData,
  input  logic       extOnWr,
  input  logic       extOnData,
  input  logic       pllOnWr,
  input  logic       pllOnData,
  input  logic       pllSrcWr,
  input  logic       pllSrcData,
  input  logic       monEnWr,
  input  logic       monEnData,
  input  logic       failClrWr,
  input  logic       failClrData,
  input  logic       extLossIn,
  input  srcSel_e    statusQ,
  input  srcSel_e    reqQ,
  input  logic       extOnQ,
  input  logic       pllOnQ,
  input  logic       pllFromExtQ,
  input  logic       monEnQ,
  input  logic       intRdy,
  input  logic       extRdy,
  input  logic       pllRdy,
  output ctlStrobe_t stb
);

  logic monActive;
  logic lossHit;
  logic forced;
  logic targetRdy;

  // Guard is armed only with the oscillator enabled and reporting ready.
  assign monActive = monEnQ & extOnQ & extRdy;
  assign lossHit   = monActive & extLossIn;
  assign forced    = lossHit &
                     ((statusQ == SRC_XTAL) |
                      ((statusQ == SRC_PLL) & pllFromExtQ));

  always_comb begin
    case (reqQ)
      SRC_RC:   targetRdy = intRdy;
      SRC_XTAL: targetRdy = extRdy;
      SRC_PLL:  targetRdy = pllRdy;
      default:  targetRdy = 1'b0;
    endcase
  end

  always_comb begin
    stb            = '0;
    stb.reqVal     = srcSel_e'(selData);
    stb.loadReq    = selWr & (selData != SRC_NONE) & ~forced;
    stb.commit     = ~forced & (reqQ != statusQ) & targetRdy;
    stb.forceRc    = forced;

    stb.setIntOn   = forced | (intOnWr & intOnData);
    stb.clrIntOn   = ~forced & intOnWr & ~intOnData;

    stb.clrExtOn   = lossHit | (extOnWr & ~extOnData);
    stb.setExtOn   = ~lossHit & extOnWr & extOnData;

    stb.clrPllOn   = forced | (pllOnWr & ~pllOnData);
    stb.setPllOn   = ~forced & pllOnWr & pllOnData;

    stb.loadPllSrc = pllSrcWr & ~pllOnQ;
    stb.pllSrcVal  = pllSrcData;

    stb.setMon     = monEnWr & monEnData;
    stb.clrMon     = monEnWr & ~monEnData;

    stb.setFail    = lossHit;
    stb.clrFail    = failClrWr & failClrData & ~lossHit;
    stb.fireBreak  = lossHit;
  end

endmodule

// File: rtl/clksw_datapath.sv
module clksw_datapath
  import clksw_pkg::*;
#(
  parameter int OFF_DELAY = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t stb,
  input  logic       intRdyIn,
  input  logic       extRdyIn,
  input  logic       pllRdyIn,
  output srcSel_e    statusQ,
  output srcSel_e    reqQ,
  output logic       intOnQ,
  output logic       extOnQ,
  output logic       pllOnQ,
  output logic       pllFromExtQ,
  output logic       monEnQ,
  output logic       failFlagQ,
  output logic       timBreakQ,
  output logic       intRdy,
  output logic       extRdy,
  output logic       pllRdy
);

  localparam int CNT_W = $clog2(OFF_DELAY + 1);

  logic [CNT_W-1:0] offCnt;
  logic             extOnD;

  always_comb begin
    extOnD = extOnQ;
    if (stb.clrExtOn)      extOnD = 1'b0;
    else if (stb.setExtOn) extOnD = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ     <= SRC_RC;
      reqQ        <= SRC_RC;
      intOnQ      <= 1'b1;
      extOnQ      <= 1'b0;
      pllOnQ      <= 1'b0;
      pllFromExtQ <= 1'b0;
      monEnQ      <= 1'b0;
      failFlagQ   <= 1'b0;
      timBreakQ   <= 1'b0;
      offCnt      <= '0;
    end else begin
      if (stb.forceRc) begin
        statusQ <= SRC_RC;
        reqQ    <= SRC_RC;
      end else begin
        if (stb.commit)  statusQ <= reqQ;
        if (stb.loadReq) reqQ    <= stb.reqVal;
      end

      if (stb.setIntOn)      intOnQ <= 1'b1;
      else if (stb.clrIntOn) intOnQ <= 1'b0;

      extOnQ <= extOnD;

      if (stb.clrPllOn)      pllOnQ <= 1'b0;
      else if (stb.setPllOn) pllOnQ <= 1'b1;

      if (stb.loadPllSrc) pllFromExtQ <= stb.pllSrcVal;

      if (stb.setMon)      monEnQ <= 1'b1;
      else if (stb.clrMon) monEnQ <= 1'b0;

      if (stb.setFail)      failFlagQ <= 1'b1;
      else if (stb.clrFail) failFlagQ <= 1'b0;

      timBreakQ <= stb.fireBreak;

      // Ready-flag wind-down after the enable is removed.
      if (extOnQ && !extOnD)  offCnt <= CNT_W'(OFF_DELAY);
      else if (extOnD)        offCnt <= '0;
      else if (offCnt != '0)  offCnt <= offCnt - CNT_W'(1);
    end
  end

  assign intRdy = intRdyIn & intOnQ;
  assign pllRdy = pllRdyIn & pllOnQ;
  assign extRdy = extRdyIn & (extOnQ | (offCnt != '0));

  assert_status_legal_R1: assert property (@(posedge clk) disable iff (!rstN)
    statusQ != SRC_NONE);

  assert_pll_switch_ready_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((statusQ != $past(statusQ)) && (statusQ == SRC_PLL)) |-> $past(pllRdy));

  assert_pll_src_locked_R5: assert property (@(posedge clk) disable iff (!rstN)
    (pllFromExtQ != $past(pllFromExtQ)) |-> !$past(pllOnQ));

  assert_loss_effects_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(failFlagQ) |-> (!extOnQ && timBreakQ));

  assert_break_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    timBreakQ |=> !timBreakQ);

  assert_pll_fallback_R8: assert property (@(posedge clk) disable iff (!rstN)
    (timBreakQ && ($past(statusQ) == SRC_PLL) && $past(pllFromExtQ))
      |-> ((statusQ == SRC_RC) && !pllOnQ));

endmodule

// File: rtl/clksw_top.sv
module clksw_top
  import clksw_pkg::*;
#(
  parameter int OFF_DELAY = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       selWr,
  input  logic [1:0] selData,
  input  logic       intOnWr,
  input  logic       intOnData,
  input  logic       extOnWr,
  input  logic       extOnData,
  input  logic       pllOnWr,
  input  logic       pllOnData,
  input  logic       pllSrcWr,
  input  logic       pllSrcData,
  input  logic       monEnWr,
  input  logic       monEnData,
  input  logic       failClrWr,
  input  logic       failClrData,
  input  logic       intRdyIn,
  input  logic       extRdyIn,
  input  logic       pllRdyIn,
  input  logic       extLossIn,
  output logic [1:0] clkSel,
  output logic [1:0] selStatus,
  output logic       intOn,
  output logic       extOn,
  output logic       pllOn,
  output logic       pllFromExt,
  output logic       monEn,
  output logic       intRdy,
  output logic       extRdy,
  output logic       pllRdy,
  output logic       failFlag,
  output logic       nmiReq,
  output logic       timBreak
);

  ctlStrobe_t stb;
  srcSel_e    statusQ;
  srcSel_e    reqQ;
  logic       extOnQ;
  logic       pllOnQ;
  logic       pllFromExtQ;
  logic       monEnQ;
  logic       failFlagQ;

  clksw_ctrl u_ctrl (
    .selWr       (selWr),
    .selData     (selData),
    .intOnWr     (intOnWr),
    .intOnData   (intOnData),
    .extOnWr     (extOnWr),
    .extOnData   (extOnData),
    .pllOnWr     (pllOnWr),
    .pllOnData   (pllOnData),
    .pllSrcWr    (pllSrcWr),
    .pllSrcData  (pllSrcData),
    .monEnWr     (monEnWr),
    .monEnData   (monEnData),
    .failClrWr   (failClrWr),
    .failClrData (failClrData),
    .extLossIn   (extLossIn),
    .statusQ     (statusQ),
    .reqQ        (reqQ),
    .extOnQ      (extOnQ),
    .pllOnQ      (pllOnQ),
    .pllFromExtQ (pllFromExtQ),
    .monEnQ      (monEnQ),
    .intRdy      (intRdy),
    .extRdy      (extRdy),
    .pllRdy      (pllRdy),
    .stb         (stb)
  );

  clksw_datapath #(.OFF_DELAY(OFF_DELAY)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .intRdyIn    (intRdyIn),
    .extRdyIn    (extRdyIn),
    .pllRdyIn    (pllRdyIn),
    .statusQ     (statusQ),
    .reqQ        (reqQ),
    .intOnQ      (intOn),
    .extOnQ      (extOnQ),
    .pllOnQ      (pllOnQ),
    .pllFromExtQ (pllFromExtQ),
    .monEnQ      (monEnQ),
    .failFlagQ   (failFlagQ),
    .timBreakQ   (timBreak),
    .intRdy      (intRdy),
    .extRdy      (extRdy),
    .pllRdy      (pllRdy)
  );

  assign clkSel     = statusQ;
  assign selStatus  = statusQ;
  assign extOn      = extOnQ;
  assign pllOn      = pllOnQ;
  assign pllFromExt = pllFromExtQ;
  assign monEn      = monEnQ;
  assign failFlag   = failFlagQ;
  assign nmiReq     = failFlagQ;

endmodule

// File: tb/tb_clksw_top.sv
module tb_clksw_top;

  localparam int CLK_PERIOD = 10;

  localparam int S_STATUS = 0;
  localparam int S_SEL    = 1;
  localparam int S_INTON  = 2;
  localparam int S_EXTON  = 3;
  localparam int S_PLLON  = 4;
  localparam int S_PSRC   = 5;
  localparam int S_MON    = 6;
  localparam int S_INTRDY = 7;
  localparam int S_EXTRDY = 8;
  localparam int S_PLLRDY = 9;
  localparam int S_FAIL   = 10;
  localparam int S_NMI    = 11;
  localparam int S_BRK    = 12;

  typedef struct {
    int         cyc;
    int         sig;
    logic [1:0] val;
    string      req;
  } exp_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic selWr = 1'b0, intOnWr = 1'b0, intOnData = 1'b0, extOnWr = 1'b0, extOnData = 1'b0;
  logic pllOnWr = 1'b0, pllOnData = 1'b0, pllSrcWr = 1'b0, pllSrcData = 1'b0;
  logic monEnWr = 1'b0, monEnData = 1'b0, failClrWr = 1'b0, failClrData = 1'b0;
  logic [1:0] selData = 2'b00;
  logic intRdyIn = 1'b1, extRdyIn = 1'b0, pllRdyIn = 1'b0, extLossIn = 1'b0;
  logic [1:0] clkSel, selStatus;
  logic intOn, extOn, pllOn, pllFromExt, monEn, intRdy, extRdy, pllRdy;
  logic failFlag, nmiReq, timBreak;

  int   cyc = 0;
  int   base = 0;
  int   checks = 0;
  int   failures = 0;
  exp_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  clksw_top dut (
    .clk(clk), .rstN(rstN),
    .selWr(selWr), .selData(selData),
    .intOnWr(intOnWr), .intOnData(intOnData),
    .extOnWr(extOnWr), .extOnData(extOnData),
    .pllOnWr(pllOnWr), .pllOnData(pllOnData),
    .pllSrcWr(pllSrcWr), .pllSrcData(pllSrcData),
    .monEnWr(monEnWr), .monEnData(monEnData),
    .failClrWr(failClrWr), .failClrData(failClrData),
    .intRdyIn(intRdyIn), .extRdyIn(extRdyIn), .pllRdyIn(pllRdyIn),
    .extLossIn(extLossIn),
    .clkSel(clkSel), .selStatus(selStatus),
    .intOn(intOn), .extOn(extOn), .pllOn(pllOn), .pllFromExt(pllFromExt),
    .monEn(monEn), .intRdy(intRdy), .extRdy(extRdy), .pllRdy(pllRdy),
    .failFlag(failFlag), .nmiReq(nmiReq), .timBreak(timBreak)
  );

  function automatic logic [1:0] readSig(input int sig);
    case (sig)
      S_STATUS: return selStatus;
      S_SEL:    return clkSel;
      S_INTON:  return {1'b0, intOn};
      S_EXTON:  return {1'b0, extOn};
      S_PLLON:  return {1'b0, pllOn};
      S_PSRC:   return {1'b0, pllFromExt};
      S_MON:    return {1'b0, monEn};
      S_INTRDY: return {1'b0, intRdy};
      S_EXTRDY: return {1'b0, extRdy};
      S_PLLRDY: return {1'b0, pllRdy};
      S_FAIL:   return {1'b0, failFlag};
      S_NMI:    return {1'b0, nmiReq};
      default:  return {1'b0, timBreak};
    endcase
  endfunction

  // Monitor: pops expected items at their cycle and compares.
  always @(negedge clk) begin
    while (expQ.size() > 0 && expQ[0].cyc <= cyc) begin
      exp_t item;
      logic [1:0] act;
      item = expQ.pop_front();
      act = readSig(item.sig);
      checks++;
      if (item.cyc < cyc) begin
        failures++;
        $display("FAIL %s sig %0d missed at cycle %0d actual=%0d expected=%0d",
                 item.req, item.sig, cyc, act, item.val);
      end else if (act !== item.val) begin
        failures++;
        $display("FAIL %s sig %0d cycle %0d actual=%0d expected=%0d",
                 item.req, item.sig, cyc, act, item.val);
      end
    end
  end

  task automatic expectAt(input int d, input int sig, input logic [1:0] v, input string r);
    exp_t e;
    e.cyc = base + d; e.sig = sig; e.val = v; e.req = r;
    expQ.push_back(e);
  endtask

  task automatic beginCycle();
    @(negedge clk); #1;
    base = cyc;
  endtask

  task automatic endCycle();
    @(negedge clk); #1;
    selWr = 0; intOnWr = 0; extOnWr = 0; pllOnWr = 0; pllSrcWr = 0;
    monEnWr = 0; failClrWr = 0; extLossIn = 0;
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rstN = 1'b1;
    base = cyc;
    // R2 reset state
    expectAt(1, S_STATUS, 2'd0, "R2"); expectAt(1, S_SEL, 2'd0, "R2");
    expectAt(1, S_INTON, 2'd1, "R2");  expectAt(1, S_INTRDY, 2'd1, "R2");
    expectAt(1, S_EXTON, 2'd0, "R2");  expectAt(1, S_PLLON, 2'd0, "R2");
    expectAt(1, S_FAIL, 2'd0, "R2");   expectAt(1, S_NMI, 2'd0, "R2");
    expectAt(1, S_BRK, 2'd0, "R2");
    drain();

    // R3: select external while not ready, old source stays
    beginCycle(); selWr = 1; selData = 2'b01;
    expectAt(2, S_STATUS, 2'd0, "R3"); expectAt(4, S_STATUS, 2'd0, "R3");
    endCycle(); drain();

    // R3 / R1: enable external with ready, switch completes to code 01
    beginCycle(); extOnWr = 1; extOnData = 1; extRdyIn = 1;
    expectAt(1, S_EXTON, 2'd1, "R3"); expectAt(1, S_STATUS, 2'd0, "R3");
    expectAt(2, S_STATUS, 2'd1, "R1"); expectAt(2, S_SEL, 2'd1, "R1");
    endCycle(); drain();

    // R4: pending request to RC survives a code-11 write
    beginCycle(); intRdyIn = 0; selWr = 1; selData = 2'b00;
    expectAt(2, S_STATUS, 2'd1, "R3");
    endCycle(); drain();
    beginCycle(); selWr = 1; selData = 2'b11;
    expectAt(2, S_STATUS, 2'd1, "R4");
    endCycle(); drain();
    beginCycle(); intRdyIn = 1;
    expectAt(1, S_STATUS, 2'd0, "R4");
    endCycle(); drain();
    beginCycle(); selWr = 1; selData = 2'b01;
    expectAt(2, S_STATUS, 2'd1, "R3");
    endCycle(); drain();

    // R5: PLL input select writable only while PLL off
    beginCycle(); pllSrcWr = 1; pllSrcData = 1;
    expectAt(1, S_PSRC, 2'd1, "R5");
    endCycle(); drain();
    beginCycle(); pllOnWr = 1; pllOnData = 1; pllRdyIn = 1;
    expectAt(1, S_PLLON, 2'd1, "R5"); expectAt(1, S_PLLRDY, 2'd1, "R3");
    endCycle(); drain();
    beginCycle(); pllSrcWr = 1; pllSrcData = 0;
    expectAt(1, S_PSRC, 2'd1, "R5"); expectAt(3, S_PSRC, 2'd1, "R5");
    endCycle(); drain();

    // R1: switch to PLL, code 10
    beginCycle(); selWr = 1; selData = 2'b10;
    expectAt(2, S_STATUS, 2'd2, "R1");
    endCycle(); drain();

    // R7 / R8: loss while PLL fed by external is the system clock
    beginCycle(); monEnWr = 1; monEnData = 1;
    expectAt(1, S_MON, 2'd1, "R6");
    endCycle(); drain();
    beginCycle(); extLossIn = 1;
    expectAt(1, S_EXTON, 2'd0, "R7"); expectAt(1, S_FAIL, 2'd1, "R7");
    expectAt(1, S_NMI, 2'd1, "R7");   expectAt(1, S_BRK, 2'd1, "R7");
    expectAt(1, S_STATUS, 2'd0, "R8"); expectAt(1, S_PLLON, 2'd0, "R8");
    expectAt(1, S_INTON, 2'd1, "R8");
    expectAt(2, S_BRK, 2'd0, "R7");   expectAt(2, S_NMI, 2'd1, "R7");
    expectAt(4, S_FAIL, 2'd1, "R7");  expectAt(4, S_NMI, 2'd1, "R7");
    endCycle(); drain();

    // R9: clear with 0 ignored, clear with 1 acts
    beginCycle(); failClrWr = 1; failClrData = 0;
    expectAt(1, S_FAIL, 2'd1, "R9"); expectAt(1, S_NMI, 2'd1, "R9");
    endCycle(); drain();
    beginCycle(); failClrWr = 1; failClrData = 1;
    expectAt(1, S_FAIL, 2'd0, "R9"); expectAt(1, S_NMI, 2'd0, "R9");
    endCycle(); drain();

    // R6: enabled but not ready -> loss ignored
    beginCycle(); extOnWr = 1; extOnData = 1; extRdyIn = 0;
    expectAt(1, S_EXTON, 2'd1, "R6");
    endCycle(); drain();
    beginCycle(); extLossIn = 1;
    expectAt(1, S_FAIL, 2'd0, "R6"); expectAt(1, S_EXTON, 2'd1, "R6");
    expectAt(1, S_BRK, 2'd0, "R6");
    endCycle(); drain();
    // R6: guard disabled -> loss ignored
    beginCycle(); extRdyIn = 1; monEnWr = 1; monEnData = 0;
    expectAt(1, S_MON, 2'd0, "R6");
    endCycle(); drain();
    beginCycle(); extLossIn = 1;
    expectAt(1, S_FAIL, 2'd0, "R6"); expectAt(1, S_EXTON, 2'd1, "R6");
    endCycle(); drain();
    beginCycle(); monEnWr = 1; monEnData = 1;
    expectAt(1, S_MON, 2'd1, "R6");
    endCycle(); drain();

    // R8: external as system clock, PLL running from it
    beginCycle(); pllOnWr = 1; pllOnData = 1;
    expectAt(1, S_PLLON, 2'd1, "R8");
    endCycle(); drain();
    beginCycle(); selWr = 1; selData = 2'b01;
    expectAt(2, S_STATUS, 2'd1, "R3");
    endCycle(); drain();
    beginCycle(); extLossIn = 1;
    expectAt(1, S_STATUS, 2'd0, "R8"); expectAt(1, S_PLLON, 2'd0, "R8");
    expectAt(1, S_EXTON, 2'd0, "R7");  expectAt(1, S_FAIL, 2'd1, "R7");
    endCycle(); drain();
    beginCycle(); failClrWr = 1; failClrData = 1;
    expectAt(1, S_FAIL, 2'd0, "R9");
    endCycle(); drain();

    // R8: non-forced case, system on RC, PLL fed by RC keeps running
    beginCycle(); pllSrcWr = 1; pllSrcData = 0;
    expectAt(1, S_PSRC, 2'd0, "R5");
    endCycle(); drain();
    beginCycle(); pllOnWr = 1; pllOnData = 1; extOnWr = 1; extOnData = 1;
    expectAt(1, S_PLLON, 2'd1, "R8"); expectAt(1, S_EXTON, 2'd1, "R8");
    endCycle(); drain();
    beginCycle(); extLossIn = 1;
    expectAt(1, S_FAIL, 2'd1, "R8"); expectAt(1, S_EXTON, 2'd0, "R8");
    expectAt(1, S_PLLON, 2'd1, "R8"); expectAt(1, S_STATUS, 2'd0, "R8");
    endCycle(); drain();
    beginCycle(); failClrWr = 1; failClrData = 1;
    expectAt(1, S_FAIL, 2'd0, "R9");
    endCycle(); drain();

    // R10: ready flag wind-down after disable
    beginCycle(); extOnWr = 1; extOnData = 1;
    expectAt(1, S_EXTRDY, 2'd1, "R10");
    endCycle(); drain();
    beginCycle(); extOnWr = 1; extOnData = 0;
    expectAt(1, S_EXTON, 2'd0, "R10"); expectAt(1, S_EXTRDY, 2'd1, "R10");
    expectAt(6, S_EXTRDY, 2'd1, "R10"); expectAt(7, S_EXTRDY, 2'd0, "R10");
    endCycle(); drain();

    repeat (2) @(negedge clk);
    summary();
    $finish;
  end

endmodule